// File: doc/BRIEF.md
# Single-Level Page Table Address Translator

This block maps virtual byte addresses to physical byte addresses through a linear page table held in flip-flops inside the block. Each virtual page has exactly one table slot, and the virtual page number selects that slot directly. A slot is 32 bits wide. Its top bit tells whether the page is mapped. When the page is mapped, the low bits of the slot give the physical frame number.

Software or a controlling engine fills the table through a one-entry-per-cycle write port. A client then sends a virtual address with a one-cycle request strobe. One clock later the block returns a result strobe with one of three outcomes. The first is a physical address. The second is an unmapped-page fault. The third is an out-of-range fault, raised when the address has bits set above the configured address space. The sizes of the virtual space, the physical memory and the page are parameters. The field widths are derived from them. With the defaults (16 KB space, 64 KB memory, 4 KB pages), the block uses a 14-bit virtual address with a 2-bit page number and a 12-bit offset, and produces a 16-bit physical address with a 4-bit frame number.

Top module: `pt_translator`

## Requirements
- R1: After reset, every table slot reads as unmapped, and `rsp_valid`, `rsp_paddr`, `rsp_fault_unmapped` and `rsp_fault_range` are all 0.
- R2: The page offset is the low log2(PAGE_BYTES) bits of `req_vaddr`. The page number is the next log2(ASPACE_BYTES) − log2(PAGE_BYTES) bits (bits 13:12 by default).
- R3: Bit 31 of a slot is the mapped flag. The frame number is the low log2(PMEM_BYTES) − log2(PAGE_BYTES) bits (bits 3:0 by default). Slot bits between the frame number and bit 31 have no effect.
- R4: For a mapped page, `rsp_paddr` equals the frame number shifted left by the offset width, OR-ed with the unchanged offset bits.
- R5: A request that hits a slot with bit 31 = 0 returns `rsp_fault_unmapped` = 1 and `rsp_paddr` = 0.
- R6: A request with any `req_vaddr` bit at or above log2(ASPACE_BYTES) set returns `rsp_fault_range` = 1, `rsp_fault_unmapped` = 0 and `rsp_paddr` = 0, whatever the table holds. The two fault flags are never both 1.
- R7: The response appears exactly one cycle after a `req_valid` cycle, with `rsp_valid` = 1 for that single cycle. In a cycle that follows no request, all response outputs are 0.
- R8: When `tbl_we` = 1, slot `tbl_idx` takes `tbl_data` at the clock edge. A request in the next cycle sees the new value. A request in the same cycle as the write sees the old value.
- R9: A write changes only the indexed slot. Writing 0 to a slot unmaps that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | VPN_W (2) | Slot index to write |
| tbl_data | input | 32 | Slot value to write |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | VA_PORT_W (32) | Virtual address to translate |
| rsp_valid | output | 1 | Result strobe, one cycle after a request |
| rsp_paddr | output | PA_W (16) | Physical address, 0 on fault |
| rsp_fault_unmapped | output | 1 | Page is not mapped |
| rsp_fault_range | output | 1 | Address exceeds the virtual space |

## Verification
The bench checks offsets 0x000 and 0xFFF at page edges. A design that misplaces the page/offset split, or adds the frame number instead of OR-ing it, would corrupt these addresses. It also uses a slot filled with ones between the frame field and the flag; a decoder that does not mask the frame field would leak those bits into the address. It sends addresses just past the space (0x4000) and at the top port bit. A design that drops the range check would either alias these onto a mapped page or report them as unmapped. Finally, it issues a write and a request in the same cycle, and then a request in the cycle straight after a write. A design with the wrong visibility would return the new frame too early or the stale fault too late.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam int unsigned PTE_W      = 32;
    localparam int unsigned PTE_MAP_IX = PTE_W - 1;

    typedef logic [PTE_W-1:0] pte_t;
endpackage

// File: rtl/pt_table.sv
module pt_table
    import pt_pkg::*;
#(
    parameter int unsigned VPN_W = 2,
    localparam int unsigned SLOTS = 1 << VPN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_idx,
    input  pte_t             wr_data,
    input  logic [VPN_W-1:0] rd_idx,
    output pte_t             rd_data
);
    pte_t slot_q [SLOTS];
    pte_t slot_d [SLOTS];

    always_comb begin
        slot_d = slot_q;
        if (wr_en) begin
            slot_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            slot_q <= slot_d;
        end
    end

    // Reads see registered contents: a same-cycle write is not yet visible.
    assign rd_data = slot_q[rd_idx];

    AST_TBL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> slot_q[$past(wr_idx)] == $past(wr_data)); // R8
endmodule

// File: rtl/pt_va_split.sv
module pt_va_split #(
    parameter int unsigned VA_PORT_W = 32,
    parameter int unsigned VA_W      = 14,
    parameter int unsigned OFF_W     = 12,
    localparam int unsigned VPN_W    = VA_W - OFF_W
) (
    input  logic [VA_PORT_W-1:0] vaddr,
    output logic [VPN_W-1:0]     vpn,
    output logic [OFF_W-1:0]     offset,
    output logic                 range_err
);
    assign offset = vaddr[OFF_W-1:0];
    assign vpn    = vaddr[VA_W-1:OFF_W];

    generate
        if (VA_PORT_W > VA_W) begin : g_range_chk
            assign range_err = |vaddr[VA_PORT_W-1:VA_W];
        end else begin : g_no_range_chk
            assign range_err = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/pt_compose.sv
module pt_compose
    import pt_pkg::*;
#(
    parameter int unsigned OFF_W = 12,
    parameter int unsigned PFN_W = 4,
    localparam int unsigned PA_W = PFN_W + OFF_W
) (
    input  pte_t             entry,
    input  logic [OFF_W-1:0] offset,
    output logic             mapped,
    output logic [PA_W-1:0]  paddr
);
    logic [PFN_W-1:0] pfn;

    assign mapped = entry[PTE_MAP_IX];
    assign pfn    = entry[PFN_W-1:0];
    assign paddr  = {pfn, {OFF_W{1'b0}}} | {{PFN_W{1'b0}}, offset};
endmodule

// File: rtl/pt_translator.sv
module pt_translator
    import pt_pkg::*;
#(
    parameter int unsigned VA_PORT_W    = 32,
    parameter int unsigned ASPACE_BYTES = 16384,
    parameter int unsigned PMEM_BYTES   = 65536,
    parameter int unsigned PAGE_BYTES   = 4096,
    localparam int unsigned OFF_W = $clog2(PAGE_BYTES),
    localparam int unsigned VA_W  = $clog2(ASPACE_BYTES),
    localparam int unsigned PA_W  = $clog2(PMEM_BYTES),
    localparam int unsigned VPN_W = VA_W - OFF_W,
    localparam int unsigned PFN_W = PA_W - OFF_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tbl_we,
    input  logic [VPN_W-1:0]     tbl_idx,
    input  logic [PTE_W-1:0]     tbl_data,
    input  logic                 req_valid,
    input  logic [VA_PORT_W-1:0] req_vaddr,
    output logic                 rsp_valid,
    output logic [PA_W-1:0]      rsp_paddr,
    output logic                 rsp_fault_unmapped,
    output logic                 rsp_fault_range
);
    typedef struct packed {
        logic            valid;
        logic            f_unm;
        logic            f_rng;
        logic [PA_W-1:0] pa;
    } rsp_t;

    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] offset;
    logic             range_err;
    pte_t             entry;
    logic             mapped;
    logic [PA_W-1:0]  paddr;
    rsp_t             rsp_d, rsp_q;

    pt_va_split #(
        .VA_PORT_W (VA_PORT_W),
        .VA_W      (VA_W),
        .OFF_W     (OFF_W)
    ) i_split (
        .vaddr     (req_vaddr),
        .vpn       (vpn),
        .offset    (offset),
        .range_err (range_err)
    );

    pt_table #(
        .VPN_W (VPN_W)
    ) i_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_idx),
        .wr_data (tbl_data),
        .rd_idx  (vpn),
        .rd_data (entry)
    );

    pt_compose #(
        .OFF_W (OFF_W),
        .PFN_W (PFN_W)
    ) i_compose (
        .entry  (entry),
        .offset (offset),
        .mapped (mapped),
        .paddr  (paddr)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (range_err) begin
                rsp_d.f_rng = 1'b1;
            end else if (!mapped) begin
                rsp_d.f_unm = 1'b1;
            end else begin
                rsp_d.pa = paddr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid          = rsp_q.valid;
    assign rsp_paddr          = rsp_q.pa;
    assign rsp_fault_unmapped = rsp_q.f_unm;
    assign rsp_fault_range    = rsp_q.f_rng;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R7
    AST_IDLE_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_paddr == '0 && !rsp_fault_unmapped && !rsp_fault_range)); // R7
    AST_FAULT_ZEROES_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault_unmapped || rsp_fault_range) |-> rsp_paddr == '0); // R5
    AST_FAULTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_fault_unmapped && rsp_fault_range)); // R6
    AST_RANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ((req_vaddr >> VA_W) != '0)) |=> rsp_fault_range); // R6
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault_unmapped && !rsp_fault_range)
            |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])); // R4
endmodule

// File: tb/test_pt_translator.sv
module test_pt_translator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_idx = '0;
    logic [31:0] tbl_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic        rsp_fault_unmapped;
    logic        rsp_fault_range;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pt_translator i_pt_translator (
        .clk                (clk),
        .rst_n              (rst_n),
        .tbl_we             (tbl_we),
        .tbl_idx            (tbl_idx),
        .tbl_data           (tbl_data),
        .req_valid          (req_valid),
        .req_vaddr          (req_vaddr),
        .rsp_valid          (rsp_valid),
        .rsp_paddr          (rsp_paddr),
        .rsp_fault_unmapped (rsp_fault_unmapped),
        .rsp_fault_range    (rsp_fault_range)
    );

    // {vaddr, expected paddr, expected unmapped, expected range}
    // Table: slot0=0x8000000C, slot1=0, slot2=0, slot3=0x80000006
    localparam int NV = 10;
    localparam logic [49:0] VECS [NV] = '{
        {32'h0000_3229, 16'h6229, 1'b0, 1'b0},  // R4
        {32'h0000_1369, 16'h0000, 1'b1, 1'b0},  // R5
        {32'h0000_1E80, 16'h0000, 1'b1, 1'b0},  // R5
        {32'h0000_2556, 16'h0000, 1'b1, 1'b0},  // R5
        {32'h0000_3A1E, 16'h6A1E, 1'b0, 1'b0},  // R4
        {32'h0000_0000, 16'hC000, 1'b0, 1'b0},  // R2 low edge
        {32'h0000_0FFF, 16'hCFFF, 1'b0, 1'b0},  // R2 high offset edge
        {32'h0000_3FFF, 16'h6FFF, 1'b0, 1'b0},  // R2 top of space
        {32'h0000_4000, 16'h0000, 1'b0, 1'b1},  // R6 first byte past space
        {32'h8000_0000, 16'h0000, 1'b0, 1'b1}   // R6 top port bit
    };

    task automatic chk(string tag, logic ev, logic [15:0] epa, logic eu, logic er);
        n_chk++;
        if (rsp_valid !== ev || rsp_paddr !== epa ||
            rsp_fault_unmapped !== eu || rsp_fault_range !== er) begin
            n_err++;
            $display("FAIL %s: got v=%0b pa=%h unm=%0b rng=%0b, expected v=%0b pa=%h unm=%0b rng=%0b",
                     tag, rsp_valid, rsp_paddr, rsp_fault_unmapped, rsp_fault_range,
                     ev, epa, eu, er);
        end
    endtask

    task automatic tbl_write(logic [1:0] idx, logic [31:0] data);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = idx; tbl_data = data;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic lookup(logic [31:0] va);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", 1'b0, 16'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        lookup(32'h0000_0123);
        chk("R1 slot empty after reset", 1'b1, 16'h0, 1'b1, 1'b0);

        tbl_write(2'd0, 32'h8000_000C);
        tbl_write(2'd1, 32'h0000_0000);
        tbl_write(2'd2, 32'h0000_0000);
        tbl_write(2'd3, 32'h8000_0006);

        for (int i = 0; i < NV; i++) begin
            lookup(VECS[i][49:18]);
            chk(VECS[i][0] ? "R6 vector" : (VECS[i][1] ? "R5 vector" : "R4/R2 vector"),
                1'b1, VECS[i][17:2], VECS[i][1], VECS[i][0]);
        end

        // R7: idle cycle after a response clears everything
        @(negedge clk);
        chk("R7 idle cycle", 1'b0, 16'h0, 1'b0, 1'b0);

        // R7: back-to-back requests, one result per cycle
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 32'h0000_0010;
        @(negedge clk);
        req_vaddr = 32'h0000_3020;
        chk("R7 back-to-back first", 1'b1, 16'hC010, 1'b0, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 back-to-back second", 1'b1, 16'h6020, 1'b0, 1'b0);

        // R3: ones between frame field and flag are ignored
        tbl_write(2'd1, 32'hFFFF_FFF5);
        lookup(32'h0000_1ABC);
        chk("R3 upper entry bits ignored", 1'b1, 16'h5ABC, 1'b0, 1'b0);

        // R6: range fault wins over a mapped slot aliasing the low bits
        lookup(32'h0001_1ABC);
        chk("R6 range beats mapped", 1'b1, 16'h0, 1'b0, 1'b1);

        // R8: same-cycle write and lookup sees old (unmapped) slot 2
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 2'd2; tbl_data = 32'h8000_0009;
        req_valid = 1'b1; req_vaddr = 32'h0000_2001;
        @(negedge clk);
        tbl_we = 1'b0;
        chk("R8 same-cycle lookup sees old", 1'b1, 16'h0, 1'b1, 1'b0);
        // request still held: this is the cycle right after the write
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 next-cycle lookup sees new", 1'b1, 16'h9001, 1'b0, 1'b0);

        // R9: unmap slot 3, others unaffected
        tbl_write(2'd3, 32'h0000_0000);
        lookup(32'h0000_3000);
        chk("R9 cleared slot faults", 1'b1, 16'h0, 1'b1, 1'b0);
        lookup(32'h0000_0010);
        chk("R9 slot 0 untouched", 1'b1, 16'hC010, 1'b0, 1'b0);
        lookup(32'h0000_2FFF);
        chk("R9 slot 2 untouched", 1'b1, 16'h9FFF, 1'b0, 1'b0);

        // R1: reset clears the table again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 outputs in reset", 1'b0, 16'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        lookup(32'h0000_0010);
        chk("R1 table cleared by reset", 1'b1, 16'h0, 1'b1, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule